// File: doc/BRIEF.md
# Programmable Panel Control Timing Generator

This block drives the per-line control strobes of a synchronous TFT panel. Each control edge sits at its own programmed distance, counted in pixel clocks, from a line-start pulse. That pulse comes from the horizontal timing logic. One line counter serves every edge, and each edge is found by comparing that counter with a programmed delay.

Four outputs are produced:
- a one-cycle start pulse;
- a clock-select strobe with separate rise and fall counts;
- a power-select strobe with separate fall and rise counts, idling high;
- a polarity-reversal level that flips once per line.

The delay inputs are captured when a line starts. Software may therefore rewrite them at any time, and a new value takes effect on the following line. The block carries no data stream, so every pin is a plain control or configuration pin with no handshake.

Timing convention: the clock edge that samples `line_start` high is offset 0. An event at offset D updates its output on the clock edge D cycles later.

Top module: `panel_ctrl_timer`

## Requirements
- R1: While `rst_n` is low, and up to the first event after reset, `start_pulse`, `clk_sel` and `pol_rev` are 0 and `pwr_sel` is 1.
- R2: `start_pulse` is high for exactly one cycle, at offset `dly_start` minus one. A `dly_start` of 0 behaves like 1, giving offset 0.
- R3: `clk_sel` goes to 1 at offset `dly_cs_rise`.
- R4: `clk_sel` goes to 0 at offset `dly_cs_fall`.
- R5: When a strobe's rise and fall offsets are equal, the fall wins and the strobe is 0 after that offset. This applies to both `clk_sel` and `pwr_sel`.
- R6: `pwr_sel` goes to 0 at offset `dly_pw_fall` and to 1 at offset `dly_pw_rise`.
- R7: `pol_rev` inverts exactly once per line, at offset `dly_rev`, and holds its level at every other cycle and across lines.
- R8: All delay inputs are captured on the line-start edge. A change made in mid-line has no effect until the next line start.
- R9: A new `line_start` restarts counting from offset 0 even in mid-line. Once the count passes 4095, or before the first line start, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Display pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle line reference pulse |
| dly_start | input | 12 | Start-pulse count; the pulse fires one cycle earlier than this count |
| dly_cs_rise | input | 12 | Clock-select rise offset |
| dly_cs_fall | input | 12 | Clock-select fall offset |
| dly_pw_fall | input | 12 | Power-select fall offset |
| dly_pw_rise | input | 12 | Power-select rise offset |
| dly_rev | input | 12 | Polarity-reversal toggle offset |
| start_pulse | output | 1 | Start pulse |
| clk_sel | output | 1 | Clock-select strobe |
| pwr_sel | output | 1 | Power-select strobe |
| pol_rev | output | 1 | Polarity-reversal level |

## Verification
The assertions check several properties on every cycle:
- the reset levels;
- that a start pulse lasts one cycle unless a new line restarts it;
- that the polarity level moves only on its own match;
- that an equal rise and fall leaves a strobe low;
- that captured delays stay still between line starts;
- that a saturated counter leaves every output quiet.

The exact placement of each edge at its programmed offset needs the bench's scenarios, which compare the outputs with a cycle model on every cycle. The same applies to the offset-minus-one rule and the zero clamp of the start pulse, to the deferral of mid-line delay writes, and to restarts caused by early line starts.

// File: rtl/panel_tmg_pkg.sv
package panel_tmg_pkg;
  localparam int NCH     = 6;
  localparam int CH_STRT = 0;
  localparam int CH_CS_R = 1;
  localparam int CH_CS_F = 2;
  localparam int CH_PW_F = 3;
  localparam int CH_PW_R = 4;
  localparam int CH_REV  = 5;
endpackage

// File: rtl/ptg_line_counter.sv
module ptg_line_counter #(
  parameter int DW = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_start,
  output logic [DW:0] pos
);
  localparam logic [DW:0] SAT = {1'b1, {DW{1'b0}}};
  localparam logic [DW:0] ONE = {{DW{1'b0}}, 1'b1};

  logic [DW:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= SAT;
    else if (line_start)  cnt_q <= ONE;
    else if (cnt_q != SAT) cnt_q <= cnt_q + ONE;
  end

  // offset of the current edge relative to the last line start
  assign pos = line_start ? '0 : cnt_q;

  a_r9_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == SAT && !line_start) |=> (cnt_q == SAT));
endmodule

// File: rtl/ptg_event_match.sv
module ptg_event_match #(
  parameter int DW  = 12,
  parameter int NCH = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   line_start,
  input  logic [NCH-1:0][DW-1:0] cfg,
  input  logic [DW:0]            pos,
  output logic [NCH-1:0]         hit
);
  logic [NCH-1:0][DW-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          lat_q <= '0;
    else if (line_start) lat_q <= cfg;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    logic [DW-1:0] eff;
    assign eff    = line_start ? cfg[g] : lat_q[g];
    assign hit[g] = (pos == {1'b0, eff});
  end

  a_r8_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(lat_q));
endmodule

// File: rtl/ptg_set_clr.sv
module ptg_set_clr #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= RST_VAL;
    else if (clr)  q <= 1'b0;
    else if (set)  q <= 1'b1;
  end

  a_r5_fall_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set && clr) |=> !q);
endmodule

// File: rtl/panel_ctrl_timer.sv
module panel_ctrl_timer
  import panel_tmg_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          pix_clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic [DW-1:0] dly_start,
  input  logic [DW-1:0] dly_cs_rise,
  input  logic [DW-1:0] dly_cs_fall,
  input  logic [DW-1:0] dly_pw_fall,
  input  logic [DW-1:0] dly_pw_rise,
  input  logic [DW-1:0] dly_rev,
  output logic          start_pulse,
  output logic          clk_sel,
  output logic          pwr_sel,
  output logic          pol_rev
);
  localparam logic [DW:0] SAT = {1'b1, {DW{1'b0}}};

  logic [DW:0]            pos;
  logic [NCH-1:0][DW-1:0] cfg;
  logic [NCH-1:0]         hit;
  logic [DW-1:0]          strt_off;
  logic                   strt_q, rev_q;

  // start pulse sits one count early; zero is clamped to zero
  assign strt_off = (dly_start == '0) ? '0 : dly_start - 1'b1;

  always_comb begin
    cfg          = '0;
    cfg[CH_STRT] = strt_off;
    cfg[CH_CS_R] = dly_cs_rise;
    cfg[CH_CS_F] = dly_cs_fall;
    cfg[CH_PW_F] = dly_pw_fall;
    cfg[CH_PW_R] = dly_pw_rise;
    cfg[CH_REV]  = dly_rev;
  end

  ptg_line_counter #(.DW(DW)) u_cnt (
    .clk(pix_clk), .rst_n(rst_n), .line_start(line_start), .pos(pos));

  ptg_event_match #(.DW(DW), .NCH(NCH)) u_match (
    .clk(pix_clk), .rst_n(rst_n), .line_start(line_start),
    .cfg(cfg), .pos(pos), .hit(hit));

  ptg_set_clr #(.RST_VAL(1'b0)) u_cs (
    .clk(pix_clk), .rst_n(rst_n),
    .set(hit[CH_CS_R]), .clr(hit[CH_CS_F]), .q(clk_sel));

  ptg_set_clr #(.RST_VAL(1'b1)) u_pw (
    .clk(pix_clk), .rst_n(rst_n),
    .set(hit[CH_PW_R]), .clr(hit[CH_PW_F]), .q(pwr_sel));

  always_ff @(posedge pix_clk) begin
    if (!rst_n) begin
      strt_q <= 1'b0;
      rev_q  <= 1'b0;
    end else begin
      strt_q <= hit[CH_STRT];
      rev_q  <= rev_q ^ hit[CH_REV];
    end
  end

  assign start_pulse = strt_q;
  assign pol_rev     = rev_q;

  a_r1_reset_state: assert property (@(posedge pix_clk)
    !rst_n |=> (!start_pulse && !clk_sel && pwr_sel && !pol_rev));

  a_r2_start_single: assert property (@(posedge pix_clk) disable iff (!rst_n)
    start_pulse |=> (!start_pulse || $past(line_start)));

  a_r7_rev_on_match: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (pol_rev != $past(pol_rev)) |-> $past(hit[CH_REV]));

  a_r9_idle_quiet: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (pos == SAT) |=> ($stable(clk_sel) && $stable(pwr_sel) &&
                      $stable(pol_rev) && !start_pulse));
endmodule

// File: tb/test_panel_ctrl_timer.sv
`timescale 1ns/1ps
module test_panel_ctrl_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ls = 1'b0;
  logic [11:0] d_st = 12'd0, d_cr = 12'd0, d_cf = 12'd0;
  logic [11:0] d_pf = 12'd0, d_pr = 12'd0, d_rv = 12'd0;
  logic o_st, o_cs, o_pw, o_rv;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  panel_ctrl_timer i_panel_ctrl_timer (
    .pix_clk(clk), .rst_n(rst_n), .line_start(ls),
    .dly_start(d_st), .dly_cs_rise(d_cr), .dly_cs_fall(d_cf),
    .dly_pw_fall(d_pf), .dly_pw_rise(d_pr), .dly_rev(d_rv),
    .start_pulse(o_st), .clk_sel(o_cs), .pwr_sel(o_pw), .pol_rev(o_rv));

  // reference model state
  int  m_n;
  bit  m_act;
  int  m_st, m_cr, m_cf, m_pf, m_pr, m_rv;
  logic e_st, e_cs, e_pw, e_rv;

  function automatic logic strobe_next(logic prev, bit up, bit dn);
    if (dn) return 1'b0;
    if (up) return 1'b1;
    return prev;
  endfunction

  function automatic int start_off(logic [11:0] v);
    return (v == 0) ? 0 : int'(v) - 1;
  endfunction

  task automatic chk(string tag, string nm, logic got, logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got=%b exp=%b at %0t", tag, nm, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_act = 0; m_n = 0;
      e_st = 0; e_cs = 0; e_pw = 1; e_rv = 0;
      return;
    end
    if (ls) begin
      m_act = 1; m_n = 0;
      m_st = start_off(d_st); m_cr = d_cr; m_cf = d_cf;
      m_pf = d_pf; m_pr = d_pr; m_rv = d_rv;
    end else if (m_act) m_n++;
    e_st = m_act && (m_n == m_st);
    e_cs = strobe_next(e_cs, m_act && m_n == m_cr, m_act && m_n == m_cf);
    e_pw = strobe_next(e_pw, m_act && m_n == m_pr, m_act && m_n == m_pf);
    e_rv = e_rv ^ (m_act && m_n == m_rv);
  endtask

  // one clock: model at posedge, compare at negedge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2", "start_pulse", o_st, e_st);
    chk("R3/R4", "clk_sel", o_cs, e_cs);
    chk("R6", "pwr_sel", o_pw, e_pw);
    chk("R7", "pol_rev", o_rv, e_rv);
  endtask

  task automatic run_line(int len);
    ls = 1'b1; step(); ls = 1'b0;
    for (int i = 1; i < len; i++) step();
  endtask

  task automatic set_cfg(int st, int cr, int cf, int pf, int pr, int rv);
    d_st = 12'(st); d_cr = 12'(cr); d_cf = 12'(cf);
    d_pf = 12'(pf); d_pr = 12'(pr); d_rv = 12'(rv);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    for (int i = 0; i < 3; i++) step();
    chk("R1", "pwr_sel reset", o_pw, 1'b1);
    chk("R1", "clk_sel reset", o_cs, 1'b0);
    rst_n = 1'b1;
    // R9: idle before first line, no activity even with zero delays
    for (int i = 0; i < 5; i++) step();
    chk("R9", "pol_rev idle", o_rv, 1'b0);
    chk("R1", "start idle", o_st, 1'b0);

    // R2/R3/R4/R6/R7 basic directed line
    set_cfg(5, 3, 9, 2, 7, 4);
    run_line(12);
    // R2: zero and one both pulse at offset 0
    set_cfg(0, 1, 2, 1, 2, 0);
    ls = 1'b1; step(); ls = 1'b0;
    chk("R2", "start at offset0 (dly 0)", o_st, 1'b1);
    chk("R7", "rev at offset0", o_rv, 1'b0);
    for (int i = 0; i < 4; i++) step();
    set_cfg(1, 1, 2, 1, 2, 0);
    run_line(5);
    // R5: equal rise and fall -> low
    set_cfg(3, 6, 6, 8, 8, 2);
    run_line(10);
    chk("R5", "clk_sel equal", o_cs, 1'b0);
    chk("R5", "pwr_sel equal", o_pw, 1'b0);
    // R8: mid-line change deferred
    set_cfg(2, 10, 30, 5, 20, 15);
    ls = 1'b1; step(); ls = 1'b0;
    for (int i = 1; i < 6; i++) step();
    set_cfg(2, 3, 50, 5, 20, 40);
    for (int i = 6; i < 32; i++) step();
    chk("R8", "clk_sel fell at latched 30", o_cs, 1'b0);
    run_line(45);
    // R9: restart in mid-line (back-to-back starts)
    set_cfg(4, 2, 6, 1, 3, 5);
    run_line(3); run_line(1); run_line(1); run_line(10);
    // R9: long count, saturation
    set_cfg(4095, 4094, 4095, 100, 4095, 4095);
    run_line(4110);
    chk("R9", "pol_rev after max", o_rv, e_rv);

    // constrained random lines with occasional mid-line writes
    for (int l = 0; l < 150; l++) begin
      int len;
      len = 1 + int'($urandom % 80);
      if ($urandom % 8 == 0) begin
        int v;
        v = int'($urandom % 64);
        set_cfg(int'($urandom % 64), v, v, v, v, int'($urandom % 64));
      end else
        set_cfg(int'($urandom % 64), int'($urandom % 64), int'($urandom % 64),
                int'($urandom % 64), int'($urandom % 64), int'($urandom % 64));
      ls = 1'b1; step(); ls = 1'b0;
      for (int i = 1; i < len; i++) begin
        if ($urandom % 16 == 0) d_cr = 12'($urandom % 64);
        if ($urandom % 16 == 0) d_rv = 12'($urandom % 64);
        if ($urandom % 16 == 0) d_st = 12'($urandom % 64);
        step();
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule